// File: doc/BRIEF.md
# PHY Test Interface Master

This block sequences the configuration test port of a PHY. The port has a test clock, a test enable, a test clear, a data-in byte driven into the PHY and a data-out byte read back from it. A single-request command interface supplies an operation code, an 8-bit register address (the test code) and an 8-bit value. The block then runs that operation's pin sequence step by step. Each pin state is held for a settle time given in system clock cycles. At the end it returns the byte it sampled from the PHY and pulses `done`.

The code phase presents the address. The PHY takes it on the falling test clock while enable is high. The data phase presents the value, which the PHY takes on the rising test clock while enable is low. A write runs both phases and returns the byte the PHY reports afterwards. A read samples the PHY between the two phases, returns that byte, and writes the same byte back, so the register keeps its contents. Two further operations set or release the test clear line. The PHY reset procedure uses them.

Top module: `phy_testif_master`

## Requirements
- R1: After reset, and at once during an asynchronous reset, `phy_test_clk`, `phy_test_en`, `phy_test_clr` and `phy_test_din` are low, `busy` and `done` are low and `result` is zero.
- R2: A request is accepted on a rising clock edge where `req_valid` is high and `busy` is low, and `busy` is high after that edge. `req_op` is encoded as 0 = write, 1 = read, 2 = set test clear, 3 = release test clear.
- R3: A request presented while `busy` is high changes nothing. The running pin sequence continues unchanged, and no further operation starts after `done`.
- R4: A write or read starts with five code-phase steps, in this order: (0) clock high, with data-in keeping its previous value; (1) data-in becomes the code; (2) enable high; (3) clock low; (4) enable low.
- R5: Three data-phase steps follow: (5) clock low; (6) data-in becomes the value; (7) clock high, with enable low. For a write the value is `req_data`.
- R6: Every step holds its pin state for exactly SETTLE_CYC = CYC_PER_US * SETTLE_US clock cycles. A write or read therefore ends with `done` exactly 8 * SETTLE_CYC cycles after the accepting edge.
- R7: A write returns in `result` the data-out byte sampled at the end of step 7.
- R8: A read samples data-out at the end of step 4. It returns that byte in `result` and drives the same byte on data-in in step 6, so the PHY register keeps its contents.
- R9: `done` is a single-cycle pulse.
- R10: `busy` stays high for every cycle of every step and falls in the same cycle that `done` rises.
- R11: `result` changes only in a cycle where `done` is high, and holds its value between completions.
- R12: A test clear operation is a single step that drives `phy_test_clr` high (op 2) or low (op 3) for SETTLE_CYC cycles and then pulses `done`. `result` and the other pins stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 0 write, 1 read, 2 set clear, 3 release clear |
| req_code | input | DATA_W | Test code (PHY register address) |
| req_data | input | DATA_W | Value for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Byte returned by the last write or read |
| phy_test_clk | output | 1 | Test clock to PHY |
| phy_test_en | output | 1 | Test enable to PHY |
| phy_test_clr | output | 1 | Test clear to PHY |
| phy_test_din | output | DATA_W | Test data into PHY |
| phy_test_dout | input | DATA_W | Test data from PHY |

## Verification
The bench attaches a behavioural PHY that takes the code on a falling clock with enable high and the data on a rising clock with enable low. Its registers start at address XOR 0xA5. Writes and reads are interleaved on the same and different addresses: a write followed by a read of the same address proves the write was stored, and reads of untouched addresses (0x00, 0x10) tell a returned sample apart from a leftover result. Repeated reads and final checks of the model's registers separate a read that writes back its sample from one that writes back stale data. Each cycle of every step is compared with the expected pin levels, so a swapped step order and a wrong step length are both caught. A request injected mid-sequence, the clear operations and an asynchronous reset partway through an operation complete the set.

// File: rtl/phy_testif_pkg.sv
package phy_testif_pkg;

   typedef enum logic [1:0] {
      OP_WRITE   = 2'd0,
      OP_READ    = 2'd1,
      OP_CLR_SET = 2'd2,
      OP_CLR_REL = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE   = 4'd0,
      ST_CK_HI  = 4'd1,
      ST_CODE   = 4'd2,
      ST_EN_HI  = 4'd3,
      ST_CK_LO  = 4'd4,
      ST_EN_LO  = 4'd5,
      ST_DCK_LO = 4'd6,
      ST_DATA   = 4'd7,
      ST_DCK_HI = 4'd8,
      ST_CLR    = 4'd9
   } step_e;

   // Successor inside a write/read sequence.
   function automatic step_e step_after(input step_e s);
      case (s)
         ST_CK_HI:  return ST_CODE;
         ST_CODE:   return ST_EN_HI;
         ST_EN_HI:  return ST_CK_LO;
         ST_CK_LO:  return ST_EN_LO;
         ST_EN_LO:  return ST_DCK_LO;
         ST_DCK_LO: return ST_DATA;
         ST_DATA:   return ST_DCK_HI;
         default:   return ST_IDLE;
      endcase
   endfunction

   function automatic logic is_clear_op(input op_e o);
      return o[1];
   endfunction

   function automatic logic is_last_step(input step_e s);
      return (s == ST_DCK_HI) || (s == ST_CLR);
   endfunction

endpackage

// File: rtl/phy_testif_timer.sv
module phy_testif_timer #(
   parameter int unsigned SETTLE_CYC = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expire
);
   localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

   generate
      if (SETTLE_CYC == 1) begin : g_single
         // Every step lasts one cycle: always at its end.
         assign expire = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (load)
               cnt_q <= CW'(SETTLE_CYC - 1);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign expire = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/phy_testif_seq.sv
module phy_testif_seq
   import phy_testif_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  req_valid,
   input  op_e   req_op,
   input  logic  expire,
   output logic  busy,
   output logic  accept,
   output logic  adv,
   output step_e nxt_step,
   output op_e   cur_op,
   output logic  sample,
   output logic  finish,
   output logic  done
);
   step_e step_q;
   op_e   op_q;
   logic  done_q;

   assign busy   = (step_q != ST_IDLE);
   assign accept = req_valid && !busy;
   assign cur_op = accept ? req_op : op_q;
   assign sample = busy && expire && (step_q == ST_EN_LO) && (op_q == OP_READ);
   assign done   = done_q;

   always_comb begin
      nxt_step = step_q;
      adv      = 1'b0;
      finish   = 1'b0;
      if (step_q == ST_IDLE) begin
         if (accept) begin
            adv      = 1'b1;
            nxt_step = is_clear_op(req_op) ? ST_CLR : ST_CK_HI;
         end
      end else if (expire) begin
         if (is_last_step(step_q)) begin
            finish   = 1'b1;
            nxt_step = ST_IDLE;
         end else begin
            adv      = 1'b1;
            nxt_step = step_after(step_q);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_IDLE;
         op_q   <= OP_WRITE;
         done_q <= 1'b0;
      end else begin
         step_q <= nxt_step;
         done_q <= finish;
         if (accept)
            op_q <= req_op;
      end
   end

endmodule

// File: rtl/phy_testif_pins.sv
module phy_testif_pins
   import phy_testif_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  step_e             nxt_step,
   input  op_e               cur_op,
   input  logic [DATA_W-1:0] code_q,
   input  logic [DATA_W-1:0] data_q,
   input  logic [DATA_W-1:0] rd_byte,
   output logic              tclk,
   output logic              ten,
   output logic              tclr,
   output logic [DATA_W-1:0] din
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tclk <= 1'b0;
         ten  <= 1'b0;
         tclr <= 1'b0;
         din  <= '0;
      end else if (adv) begin
         case (nxt_step)
            ST_CK_HI:  tclk <= 1'b1;
            ST_CODE:   din  <= code_q;
            ST_EN_HI:  ten  <= 1'b1;
            ST_CK_LO:  tclk <= 1'b0;
            ST_EN_LO:  ten  <= 1'b0;
            ST_DCK_LO: tclk <= 1'b0;
            ST_DATA:   din  <= (cur_op == OP_READ) ? rd_byte : data_q;
            ST_DCK_HI: tclk <= 1'b1;
            ST_CLR:    tclr <= (cur_op == OP_CLR_SET);
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/phy_testif_capture.sv
module phy_testif_capture
   import phy_testif_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] req_code,
   input  logic [DATA_W-1:0] req_data,
   input  logic              sample,
   input  logic              finish,
   input  op_e               fin_op,
   input  logic [DATA_W-1:0] test_dout,
   output logic [DATA_W-1:0] code_q,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] rd_byte,
   output logic [DATA_W-1:0] result
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         data_q  <= '0;
         rd_byte <= '0;
         result  <= '0;
      end else begin
         if (accept) begin
            code_q <= req_code;
            data_q <= req_data;
         end
         if (sample)
            rd_byte <= test_dout;
         if (finish) begin
            case (fin_op)
               OP_WRITE: result <= test_dout;
               OP_READ:  result <= rd_byte;
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/phy_testif_master.sv
module phy_testif_master
   import phy_testif_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CYC_PER_US = 250,
   parameter int unsigned SETTLE_US  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [DATA_W-1:0] req_code,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              phy_test_clk,
   output logic              phy_test_en,
   output logic              phy_test_clr,
   output logic [DATA_W-1:0] phy_test_din,
   input  logic [DATA_W-1:0] phy_test_dout
);
   localparam int unsigned SETTLE_CYC = CYC_PER_US * SETTLE_US;

   if (DATA_W < 1) begin : g_bad_width
      $error("phy_testif_master: DATA_W must be at least 1");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("phy_testif_master: settle time must be at least one cycle");
   end

   logic              accept, adv, sample, finish, expire;
   step_e             nxt_step;
   op_e               cur_op;
   logic [DATA_W-1:0] code_q, data_q, rd_byte;

   phy_testif_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (adv),
      .expire (expire)
   );

   phy_testif_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (op_e'(req_op)),
      .expire    (expire),
      .busy      (busy),
      .accept    (accept),
      .adv       (adv),
      .nxt_step  (nxt_step),
      .cur_op    (cur_op),
      .sample    (sample),
      .finish    (finish),
      .done      (done)
   );

   phy_testif_capture #(.DATA_W(DATA_W)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_code  (req_code),
      .req_data  (req_data),
      .sample    (sample),
      .finish    (finish),
      .fin_op    (cur_op),
      .test_dout (phy_test_dout),
      .code_q    (code_q),
      .data_q    (data_q),
      .rd_byte   (rd_byte),
      .result    (result)
   );

   phy_testif_pins #(.DATA_W(DATA_W)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .nxt_step (nxt_step),
      .cur_op   (cur_op),
      .code_q   (code_q),
      .data_q   (data_q),
      .rd_byte  (rd_byte),
      .tclk     (phy_test_clk),
      .ten      (phy_test_en),
      .tclr     (phy_test_clr),
      .din      (phy_test_din)
   );

endmodule

// File: rtl/phy_testif_master_chk.sv
module phy_testif_master_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SETTLE_CYC = 250
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] result,
   input logic              tclk,
   input logic              ten,
   input logic              tclr,
   input logic [DATA_W-1:0] din
);
   localparam int unsigned PW = DATA_W + 3;

   logic [PW-1:0] pins, pins_prev;
   logic [31:0]   run_q;
   logic          pin_change;

   assign pins       = {tclk, ten, tclr, din};
   assign pin_change = (pins != pins_prev);

   // Count consecutive edges at which the pin vector stayed the same.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_prev <= '0;
         run_q     <= SETTLE_CYC;
      end else begin
         pins_prev <= pins;
         if (pin_change)
            run_q <= 32'd1;
         else if (run_q < SETTLE_CYC)
            run_q <= run_q + 32'd1;
      end
   end

   a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   a_r4_en_rises_with_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ten) |-> tclk);

   a_r4_code_latch_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tclk) && ten) |-> $stable(din));

   a_r5_clk_rise_en_low_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tclk) |-> (!ten && $stable(din)));

   a_r6_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pin_change |-> (run_q >= SETTLE_CYC));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r11_result_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

endmodule

bind phy_testif_master phy_testif_master_chk #(
   .DATA_W     (DATA_W),
   .SETTLE_CYC (SETTLE_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .result    (result),
   .tclk      (phy_test_clk),
   .ten       (phy_test_en),
   .tclr      (phy_test_clr),
   .din       (phy_test_din)
);

// File: tb/phy_testif_master_tb.sv
module phy_testif_master_tb;
   localparam int unsigned CYC = 2;
   localparam int unsigned US  = 2;
   localparam int unsigned S   = CYC * US;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [7:0] req_code = 8'h00, req_data = 8'h00;
   logic       busy, done, tclk, ten, tclr;
   logic [7:0] result, din, dout;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   phy_testif_master #(.DATA_W(8), .CYC_PER_US(CYC), .SETTLE_US(US)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_op        (req_op),
      .req_code      (req_code),
      .req_data      (req_data),
      .busy          (busy),
      .done          (done),
      .result        (result),
      .phy_test_clk  (tclk),
      .phy_test_en   (ten),
      .phy_test_clr  (tclr),
      .phy_test_din  (din),
      .phy_test_dout (dout)
   );

   // Behavioural PHY register file.
   logic [7:0] mem [256];
   logic [7:0] cur_code = 8'h00;
   logic       armed = 1'b0;
   assign dout = mem[cur_code];
   always @(negedge tclk) if (ten) begin cur_code = din; armed = 1'b1; end
   always @(posedge tclk) if (!ten && armed) begin mem[cur_code] = din; armed = 1'b0; end

   typedef struct packed {
      logic [1:0] op;
      logic [7:0] code;
      logic [7:0] data;
      logic [7:0] res;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{2'd0, 8'h44, 8'h3C, 8'h3C},
      '{2'd1, 8'h44, 8'h00, 8'h3C},
      '{2'd1, 8'h10, 8'h00, 8'hB5},
      '{2'd0, 8'h10, 8'h00, 8'h00},
      '{2'd1, 8'h10, 8'h00, 8'h00},
      '{2'd0, 8'hFF, 8'hFF, 8'hFF},
      '{2'd1, 8'h00, 8'h00, 8'hA5},
      '{2'd1, 8'hFF, 8'h00, 8'hFF}
   };

   logic [7:0] prev_din = 8'h00;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [9:0] exp_pins(input int k, input logic [7:0] c,
                                           input logic [7:0] d, input logic [7:0] p);
      case (k)
         0: return {2'b10, p};
         1: return {2'b10, c};
         2: return {2'b11, c};
         3: return {2'b01, c};
         4: return {2'b00, c};
         5: return {2'b00, c};
         6: return {2'b00, d};
         default: return {2'b10, d};
      endcase
   endfunction

   task automatic run_data_op(input logic [1:0] op, input logic [7:0] code,
                              input logic [7:0] data, input logic [7:0] res, input bit poke);
      logic [7:0] d;
      bit         pin_bad, busy_bad;
      logic [9:0] got, want;
      string      preq;
      d = (op == 2'd1) ? res : data;
      pin_bad = 0; busy_bad = 0; got = '0; want = '0; preq = "R4";
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_code = code; req_data = data;
      @(posedge clk);
      for (int k = 0; k < 8; k++) begin
         for (int j = 0; j < int'(S); j++) begin
            @(negedge clk);
            if (poke && k == 2 && j == 0) begin
               req_valid = 1'b1; req_op = 2'd0; req_code = 8'h77; req_data = 8'h55;
            end else begin
               req_valid = 1'b0;
            end
            if (!pin_bad && ({tclk, ten, din} !== exp_pins(k, code, d, prev_din))) begin
               pin_bad = 1; got = {tclk, ten, din}; want = exp_pins(k, code, d, prev_din);
               preq = (k < 5) ? "R4" : "R5";
            end
            if (busy !== 1'b1 || done !== 1'b0) busy_bad = 1;
         end
      end
      check(!pin_bad, preq, "step pin sequence {clk,en,din}", 32'(got), 32'(want));
      check(!busy_bad, "R10", "busy high, done low through all steps", 32'(busy_bad), 0);
      @(negedge clk);
      check(done === 1'b1 && busy === 1'b0, "R6", "done after 8*SETTLE_CYC cycles",
            {busy, done}, 32'b01);
      check(result === res, (op == 2'd1) ? "R8" : "R7", "returned byte", 32'(result), 32'(res));
      prev_din = d;
      @(negedge clk);
      check(done === 1'b0, "R9", "done is one cycle", 32'(done), 0);
      if (poke)
         check(busy === 1'b0, "R3", "no operation started from busy-time request",
               32'(busy), 0);
   endtask

   task automatic run_clr_op(input logic [1:0] op, input logic lvl);
      logic [7:0] r0;
      bit         bad;
      r0 = result; bad = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_code = 8'hAA; req_data = 8'h55;
      @(posedge clk);
      for (int j = 0; j < int'(S); j++) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (tclr !== lvl || busy !== 1'b1 || tclk !== 1'b1 || ten !== 1'b0 || din !== prev_din)
            bad = 1;
      end
      check(!bad, "R12", "clear level held for SETTLE_CYC, other pins kept", 32'(tclr), 32'(lvl));
      @(negedge clk);
      check(done === 1'b1 && busy === 1'b0 && result === r0 && tclr === lvl, "R12",
            "clear op completes, result unchanged", {busy, done, result}, {2'b01, r0});
   endtask

   task automatic do_reset();
      rst_n = 1'b0; armed = 1'b0; req_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      prev_din = 8'h00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
      do_reset();
      @(negedge clk);
      check({tclk, ten, tclr, din, busy, done, result} === '0, "R1", "reset state",
            {tclk, ten, tclr, busy, done}, 0);

      for (int v = 0; v < 8; v++)
         run_data_op(VEC[v].op, VEC[v].code, VEC[v].data, VEC[v].res, v == 2);

      check(mem[8'h44] === 8'h3C && mem[8'h00] === 8'hA5 && mem[8'hFF] === 8'hFF, "R8",
            "reads leave PHY contents intact", 32'(mem[8'h00]), 32'hA5);
      check(mem[8'h77] === 8'hD2, "R3", "busy-time write never reached PHY",
            32'(mem[8'h77]), 32'hD2);

      run_clr_op(2'd2, 1'b1);
      run_clr_op(2'd3, 1'b0);

      // R2: accepted in the cycle right after an idle gap; R11 result held.
      @(negedge clk);
      check(busy === 1'b0 && result === 8'hFF, "R11", "result held while idle",
            32'(result), 32'hFF);
      run_data_op(2'd0, 8'h21, 8'h5A, 8'h5A, 0);
      check(busy === 1'b0, "R2", "idle after completion", 32'(busy), 0);

      // R1: asynchronous reset in the middle of an operation.
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_code = 8'h30; req_data = 8'h99;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy === 1'b1, "R2", "request accepted", 32'(busy), 1);
      repeat (2 * S) @(negedge clk);
      rst_n = 1'b0; armed = 1'b0;
      #1;
      check({tclk, ten, tclr, din, busy, done, result} === '0, "R1", "mid-operation reset",
            {tclk, ten, busy}, 0);
      @(negedge clk) rst_n = 1'b1;
      prev_din = 8'h00;
      run_data_op(2'd1, 8'h21, 8'h00, 8'h5A, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule